// File: doc/BRIEF.md
# Gate-Program S-Box Table Builder

This block runs a short, loaded program of bit-level gates over a byte-wide register file and turns it into a complete 256-entry substitution table. Each instruction is either an AND-then-XOR composite gate or a plain two-input XOR. Each one rewrites a single register bit. For every input byte, the register file starts as that byte, the active gates run in program order, and the final register contents become the table entry for that byte.

Software-side logic, or a neighbouring search engine, writes the instruction slots and the active length through a simple write port. It then pulses `start` and waits for `done`. After that it can read any table entry through a combinational read port. The block also reports whether the table it built is a bijection: the flag is high only when no output byte appears twice. The block takes one clock per gate per input byte, and at least one clock per byte when the program is empty.

Top module: `sbox_gate_eval`

## Requirements
- R1: Out of reset, `busy`, `done` and `is_perm` are all 0.
- R2: An instruction word is 13 bits. Bit 12 is the opcode, bits 11:9 the destination register, bits 8:6 operand C, bits 5:3 operand B and bits 2:0 operand A. Register i holds bit i of the byte.
- R3: Opcode 1 (AND-XOR) sets the destination to (A AND B) XOR C. No other register changes.
- R4: Opcode 0 (XOR) sets the destination to A XOR B. No other register changes.
- R5: Gates at slots 0 to length-1 are applied strictly in slot order, each seeing the result of the one before. With length 0 every entry equals its index (identity).
- R6: A length value above 64 is stored as 64.
- R7: `done` becomes visible 256*max(length,1) clock edges after the edge that samples `start`. `busy` is high in between, and `busy` and `done` are never high together.
- R8: When `done` is high, `is_perm` is 1 exactly when all 256 table entries are distinct.
- R9: `rd_data` shows the table entry at `rd_addr` in the same cycle.
- R10: Instruction and length writes presented while `busy` is high are ignored.
- R11: A `start` pulse while `busy` is high is ignored and does not change the run's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Write one instruction slot |
| ld_addr | input | 6 | Slot index to write |
| ld_instr | input | 13 | Instruction word |
| len_we | input | 1 | Write the active program length |
| len_val | input | 7 | Program length (saturated to 64) |
| start | input | 1 | Begin building the table |
| busy | output | 1 | Table build in progress |
| done | output | 1 | Table complete; held until the next start |
| rd_addr | input | 8 | Table read index |
| rd_data | output | 8 | Table entry at rd_addr |
| is_perm | output | 1 | Built table has no repeated entry |

## Verification
The bench builds the block with its default parameters: an 8-bit register file and 64 instruction slots. At these values the full program capacity can be reached, so a 64-gate run of 16384 cycles is measured, as is the saturation of an oversized length to that same capacity. At the same sizes, both a table that collapses two inputs and tables built from in-place AND-XOR chains are compared entry by entry against a bench-side interpreter of the gate semantics. Writes and start pulses arriving in the middle of a run show that a run's program is frozen once it begins.

// File: rtl/sbxe_pkg.sv
// Package: shared widths and the instruction word layout for the gate-program
// table builder. Assumes a byte-wide register file (one register per bit).
package sbxe_pkg;
    localparam int DATA_W = 8;
    localparam int SEL_W  = $clog2(DATA_W);

    typedef enum logic {
        OP_XOR    = 1'b0,
        OP_ANDXOR = 1'b1
    } gate_op_e;

    // Opcode in the top bit, then destination, operand C, operand B, operand A.
    typedef struct packed {
        gate_op_e           op;
        logic [SEL_W-1:0]   dst;
        logic [SEL_W-1:0]   src_c;
        logic [SEL_W-1:0]   src_b;
        logic [SEL_W-1:0]   src_a;
    } gate_word_t;

    localparam int WORD_W = $bits(gate_word_t);
endpackage

// File: rtl/gate_store.sv
// Module: gate_store
// Holds the instruction slots and the active program length. The length is
// saturated to the slot count. Assumes the caller gates writes while a run is
// in progress.
module gate_store
    import sbxe_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  gate_word_t       wr_word,
    input  logic             len_en,
    input  logic [LEN_W-1:0] len_in,
    input  logic [IDX_W-1:0] rd_idx,
    output gate_word_t       rd_word,
    output logic [LEN_W-1:0] len_q
);
    gate_word_t mem [DEPTH];

    // Slot array update; cleared to all-XOR words on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end
    end

    // Active length register with saturation to the slot count.
    always_ff @(posedge clk) begin
        if (!rst_n) len_q <= '0;
        else if (len_en) len_q <= (len_in > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : len_in;
    end

    assign rd_word = mem[rd_idx];

    // R6
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LEN_W'(DEPTH));
endmodule

// File: rtl/gate_alu.sv
// Module: gate_alu
// Applies one instruction to the register-file state in one combinational step.
// Only the destination bit may change. The clock and reset feed the checker only.
module gate_alu
    import sbxe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] st_in,
    input  gate_word_t        gate,
    output logic [DATA_W-1:0] st_out
);
    logic prod;  // the implicit temporary holding the AND product

    // Compute the new destination bit for the selected gate type.
    always_comb begin
        st_out = st_in;
        prod   = st_in[gate.src_a] & st_in[gate.src_b];
        if (gate.op == OP_ANDXOR) st_out[gate.dst] = prod ^ st_in[gate.src_c];
        else                      st_out[gate.dst] = st_in[gate.src_a] ^ st_in[gate.src_b];
    end

    // R3 R4
    single_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_out ^ st_in) <= 1);
endmodule

// File: rtl/sbox_table.sv
// Module: sbox_table
// Stores the built table and tracks which output values have been seen. It
// clears the permutation flag on any repeat. Assumes one write per index per run.
module sbox_table
    import sbxe_pkg::*;
#(
    localparam int ENTRIES = 1 << DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              perm
);
    logic [DATA_W-1:0]  tbl [ENTRIES];
    logic [ENTRIES-1:0] seen;

    // Table storage write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_addr] <= wr_data;
        end
    end

    // Seen-vector and bijectivity flag maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
            perm <= 1'b0;
        end else if (clr) begin
            seen <= '0;
            perm <= 1'b1;
        end else if (wr_en) begin
            seen[wr_data] <= 1'b1;
            if (seen[wr_data]) perm <= 1'b0;
        end
    end

    assign rd_data = tbl[rd_addr];

    // R8
    perm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perm) |-> $past(wr_en));
endmodule

// File: rtl/sbox_gate_eval.sv
// Module: sbox_gate_eval (top)
// Sequences the gate program over every input byte, one gate per cycle. It
// writes each finished byte into the table and raises done after the last
// entry. Assumes the program is loaded before start. Loads are ignored while busy.
module sbox_gate_eval
    import sbxe_pkg::*;
#(
    parameter int MAX_GATES = 64,
    localparam int IDX_W = $clog2(MAX_GATES),
    localparam int LEN_W = $clog2(MAX_GATES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [IDX_W-1:0]  ld_addr,
    input  logic [WORD_W-1:0] ld_instr,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              start,
    output logic              busy,
    output logic              done,
    input  logic [DATA_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              is_perm
);
    logic              busy_q, done_q, start_go, last_gate, wr_en;
    logic [DATA_W-1:0] x_q, acc_q, st_in, alu_out, result;
    logic [IDX_W-1:0]  gi_q;
    logic [LEN_W-1:0]  len_q;
    gate_word_t        cur_gate;

    assign start_go = start && !busy_q;

    gate_store #(.DEPTH(MAX_GATES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ld_we && !busy_q), .wr_addr(ld_addr), .wr_word(gate_word_t'(ld_instr)),
        .len_en(len_we && !busy_q), .len_in(len_val),
        .rd_idx(gi_q), .rd_word(cur_gate), .len_q(len_q)
    );

    // The first gate of each byte reads the byte itself; later gates read the accumulator.
    assign st_in = (gi_q == '0) ? x_q : acc_q;

    gate_alu u_alu (
        .clk(clk), .rst_n(rst_n), .st_in(st_in), .gate(cur_gate), .st_out(alu_out)
    );

    assign last_gate = (len_q == '0) || ({1'b0, gi_q} == len_q - LEN_W'(1));
    assign result    = (len_q == '0) ? x_q : alu_out;
    assign wr_en     = busy_q && last_gate;

    sbox_table u_tbl (
        .clk(clk), .rst_n(rst_n), .clr(start_go),
        .wr_en(wr_en), .wr_addr(x_q), .wr_data(result),
        .rd_addr(rd_addr), .rd_data(rd_data), .perm(is_perm)
    );

    // Run sequencer: byte counter, gate counter, accumulator and handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            x_q    <= '0;
            gi_q   <= '0;
            acc_q  <= '0;
        end else if (start_go) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            x_q    <= '0;
            gi_q   <= '0;
        end else if (busy_q) begin
            if (last_gate) begin
                gi_q <= '0;
                if (x_q == '1) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    x_q <= x_q + DATA_W'(1);
                end
            end else begin
                gi_q  <= gi_q + IDX_W'(1);
                acc_q <= alu_out;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_en && x_q == '1));
    // R10
    len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(len_q));
endmodule

// File: tb/sim_sbox_gate_eval.sv
// Bench: directed scenarios, one task each, against a bench-side gate interpreter.
module sim_sbox_gate_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0, len_we = 1'b0, start = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [12:0] ld_instr = '0;
    logic [6:0]  len_val = '0;
    logic [7:0]  rd_addr = '0;
    logic        busy, done, is_perm;
    logic [7:0]  rd_data;

    int checks = 0, errors = 0;
    logic [12:0] prog [64];

    always #2 clk = ~clk;

    sbox_gate_eval u0 (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_instr(ld_instr),
        .len_we(len_we), .len_val(len_val), .start(start), .busy(busy), .done(done),
        .rd_addr(rd_addr), .rd_data(rd_data), .is_perm(is_perm)
    );

    function automatic logic [12:0] mk(input bit op, input int d, input int c, input int b, input int a);
        return {op, 3'(d), 3'(c), 3'(b), 3'(a)};
    endfunction

    // Interpreter of R2-R5.
    function automatic logic [7:0] model(input logic [7:0] x, input int n);
        logic [7:0] r = x;
        for (int g = 0; g < n; g++) begin
            logic [12:0] w = prog[g];
            if (w[12]) r[w[11:9]] = (r[w[2:0]] & r[w[5:3]]) ^ r[w[8:6]];
            else       r[w[11:9]] = r[w[2:0]] ^ r[w[5:3]];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int n, input int lenv);
        for (int g = 0; g < n; g++) begin
            @(negedge clk); ld_we = 1; ld_addr = 6'(g); ld_instr = prog[g];
        end
        @(negedge clk); ld_we = 0; len_we = 1; len_val = 7'(lenv);
        @(negedge clk); len_we = 0;
    endtask

    // Start a run; optionally poke loads and start mid-run; return edges until done.
    task automatic run(input bit poke, output int n);
        @(negedge clk); start = 1;
        @(posedge clk);
        @(negedge clk); start = 0;
        n = 0;
        while (!done && n < 20000) begin
            @(posedge clk); @(negedge clk); n++;
            if (poke && n == 10) begin
                ld_we = 1; ld_addr = 0; ld_instr = 13'h1FFF; len_we = 1; len_val = 0; start = 1;
            end else if (poke && n == 11) begin
                ld_we = 0; len_we = 0; start = 0;
            end
        end
    endtask

    task automatic check_table(input int n, input string req);
        int bad = 0, first = -1, act = 0, exp = 0;
        bit [255:0] used = '0;
        bit distinct = 1;
        for (int x = 0; x < 256; x++) begin
            logic [7:0] e = model(8'(x), n);
            if (used[e]) distinct = 0;
            used[e] = 1;
            @(negedge clk); rd_addr = 8'(x); #1;
            if (rd_data !== e) begin
                bad++;
                if (first < 0) begin first = x; act = rd_data; exp = e; end
            end
        end
        check(bad == 0, req, act, exp);
        check(is_perm === distinct, "R8", is_perm, distinct);
    endtask

    task automatic t_reset;
        check(busy === 0 && done === 0 && is_perm === 0, "R1", {busy, done, is_perm}, 0);
    endtask

    task automatic t_identity;
        int n;
        load(0, 0);
        run(0, n);
        check(n == 256, "R7", n, 256);   // empty program: one cycle per byte
        check_table(0, "R5");
        check(is_perm === 1, "R8", is_perm, 1);
    endtask

    task automatic t_andxor_single;
        int n;
        prog[0] = mk(1, 7, 7, 1, 0);     // r7 ^= r0 & r1, in place
        load(1, 1);
        run(0, n);
        check(n == 256, "R7", n, 256);
        check_table(1, "R3");
    endtask

    task automatic t_xor_collapse;
        int n;
        prog[0] = mk(0, 0, 0, 1, 1);     // r0 = r1 ^ r1 = 0: not a bijection
        load(1, 1);
        run(0, n);
        check_table(1, "R4");
        check(is_perm === 0, "R8", is_perm, 0);
    endtask

    task automatic t_chain;
        int n;
        prog[0] = mk(1, 7, 7, 0, 1);
        prog[1] = mk(0, 0, 0, 7, 0);     // r0 = r0 ^ r7 uses the new r7
        prog[2] = mk(1, 3, 3, 5, 7);
        prog[3] = mk(0, 5, 0, 2, 5);
        load(4, 4);
        run(0, n);
        check(n == 1024, "R7", n, 1024);
        check_table(4, "R5");
    endtask

    task automatic t_full;
        int n;
        for (int g = 0; g < 64; g++) begin
            int d = g % 8;
            if (g % 3 != 0) prog[g] = mk(1, d, d, (g*5+2)%8, (g*3+1)%8);
            else            prog[g] = mk(0, d, 0, (d+3)%8, d);
        end
        load(64, 64);
        run(0, n);
        check(n == 16384, "R7", n, 16384);
        check_table(64, "R2");
        load(0, 100);                    // oversized length saturates to 64
        run(0, n);
        check(n == 16384, "R6", n, 16384);
        check_table(64, "R6");
    endtask

    task automatic t_busy_ignore;
        int n;
        prog[0] = mk(1, 2, 2, 6, 4);
        prog[1] = mk(0, 6, 0, 1, 6);
        load(2, 2);
        run(1, n);                       // mid-run writes and start pulse
        check(n == 512, "R11", n, 512);
        check_table(2, "R10");
        run(0, n);                       // rerun shows slot 0 and length untouched
        check(n == 512, "R10", n, 512);
        check_table(2, "R9");
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_andxor_single();
        t_xor_collapse();
        t_chain();
        t_full();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule